// File: doc/BRIEF.md
# Auxiliary Memory Bank Switch Controller

This block maps the CPU address space of an 8-bit machine onto physical stores: main RAM, auxiliary RAM and ROM. It watches every bus access for two soft-switch addresses. These addresses set or clear a single alternate-zero-page flag. The flag moves two regions to auxiliary RAM at once: the zero page and stack area, and the high RAM area that a language card provides.

For each access the block returns four things, all combinationally from the current address, strobes and state:
- a two-bit source select,
- a 16-bit offset into the chosen store,
- a write-enable,
- a data-out value for the CPU.

The data-out value is the incoming bus value passed through. On a status read, bit 7 is replaced with the flag. The language-card controls (card present, read enable, write inhibit, bank-1 select) arrive as plain inputs from elsewhere.

Top module: `aux_zp_mapper`

## Requirements
- R1: A read or write at 0xC008 clears the flag and one at 0xC009 sets it (address bit 0 is the new value); the new value governs mapping from the next clock cycle on.
- R2: Accesses to 0x0000–0x01FF select auxiliary RAM (code 1) while the flag is set and main RAM (code 0) while it is clear, with offset equal to the address.
- R3: Accesses to 0x0200–0xBFFF always select main RAM (code 0) with offset equal to the address, whatever the flag.
- R4: A RAM access in 0xD000–0xDFFF uses offset 0xC000 plus address bits 11:0, or 0xD000 plus those bits when bank-1 select is 1; the RAM source follows the flag.
- R5: A RAM access in 0xE000–0xFFFF uses offset equal to the address; the RAM source follows the flag.
- R6: A write to 0xD000–0xFFFF reaches RAM only when card present is 1 and write inhibit is 0; otherwise the source is none (code 3) and the write-enable stays low.
- R7: A read of 0xD000–0xFFFF returns RAM only when card present and read enable are both 1; otherwise the source is ROM (code 2) with offset ROM_BASE plus (address − 0xD000).
- R8: A read (read strobe 1, write strobe 0) of 0xC016 drives data-out bit 7 with the flag and bits 6:0 with data-in bits 6:0; at every other time data-out equals data-in.
- R9: After reset the flag is 0.
- R10: With no strobe, or for any address in 0xC000–0xCFFF, the source is none (code 3), the offset is 0 and the write-enable is low. When both strobes are high, the access is treated as a write.
- R11: The write-enable is high for every permitted RAM write and never while the write strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_din | input | 8 | Incoming bus value |
| cpu_dout | output | 8 | Data returned to the CPU |
| lc_present | input | 1 | Language card fitted |
| lc_rd_en | input | 1 | Language card RAM read enable |
| lc_wr_inh | input | 1 | Language card write inhibit |
| lc_bank1 | input | 1 | Bank-1 select for 0xD000–0xDFFF |
| map_src | output | 2 | 0 main, 1 aux, 2 ROM, 3 none |
| map_offset | output | 16 | Offset into selected store |
| map_we | output | 1 | Write-enable for permitted RAM writes |

## Verification
The bench builds the block with ROM_BASE at 0x0F00 and HAS_CARD at 1. With a non-zero ROM base, the ROM offset differs from the RAM offsets and from the raw address, so a fallback read that took the wrong path shows up as a wrong offset. With the card enabled, all sixteen combinations of present, read enable, write inhibit and bank select are reachable, under both flag values. Directed passes cover the switch addresses, the region edges and the status read. A long random pass then lets switch toggles land among region accesses.

// File: rtl/aux_map_pkg.sv
// Shared types and region decode for the auxiliary memory mapper.
// Assumes a 16-bit CPU address bus.
package aux_map_pkg;
    typedef enum logic [1:0] {
        SRC_MAIN = 2'd0,
        SRC_AUX  = 2'd1,
        SRC_ROM  = 2'd2,
        SRC_NONE = 2'd3
    } src_t;

    typedef enum logic [2:0] {
        RG_ZPSTK,
        RG_LOW,
        RG_IO,
        RG_LCD,
        RG_LCEF
    } region_t;

    // Classify an address into a mapping region.
    function automatic region_t classify(input logic [15:0] a);
        if (a[15:9] == 7'd0)            return RG_ZPSTK;
        else if (a[15:12] < 4'hC)       return RG_LOW;
        else if (a[15:12] == 4'hC)      return RG_IO;
        else if (a[15:12] == 4'hD)      return RG_LCD;
        else                            return RG_LCEF;
    endfunction
endpackage

// File: rtl/aux_zp_switch.sv
// Holds the alternate-zero-page flag. Any access (read or write) whose
// address matches SW_ADDR with bit 0 ignored loads address bit 0 into
// the flag at the next clock edge. Assumes SW_ADDR is even.
module aux_zp_switch #(
    parameter logic [15:0] SW_ADDR = 16'hC008
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] addr,
    input  logic        acc,
    output logic        flag
);
    localparam logic [14:0] SW_PAIR = SW_ADDR[15:1];

    logic hit;

    // Detect an access to either switch address.
    always_comb hit = acc && (addr[15:1] == SW_PAIR);

    // Register the flag; synchronous active-low reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (hit) flag <= addr[0];
    end
endmodule

// File: rtl/aux_zp_decode.sv
// Turns a CPU access into a physical source, an offset and a write-enable.
// Purely combinational; uses the current flag and card controls.
// Assumes the write strobe dominates when both strobes are high.
module aux_zp_decode
    import aux_map_pkg::*;
#(
    parameter logic [15:0] ROM_BASE = 16'h0000,
    parameter bit          HAS_CARD = 1'b1
) (
    input  logic [15:0] addr,
    input  logic        rd,
    input  logic        wr,
    input  logic        flag,
    input  logic        lc_present,
    input  logic        lc_rd_en,
    input  logic        lc_wr_inh,
    input  logic        lc_bank1,
    output logic [1:0]  src,
    output logic [15:0] offset,
    output logic        we
);
    localparam logic [15:0] LC_BASE = 16'hD000;

    logic    card_ok;
    region_t rg;
    src_t    ram_src;
    logic [15:0] lc_off;
    logic [15:0] rom_off;

    // Select whether a language card can ever be used.
    generate
        if (HAS_CARD) begin : g_card
            assign card_ok = lc_present;
        end else begin : g_nocard
            assign card_ok = 1'b0;
        end
    endgenerate

    // Derive region, RAM source and candidate offsets.
    always_comb begin
        rg      = classify(addr);
        ram_src = flag ? SRC_AUX : SRC_MAIN;
        if (rg == RG_LCD) lc_off = {(lc_bank1 ? 4'hD : 4'hC), addr[11:0]};
        else              lc_off = addr;
        rom_off = ROM_BASE + (addr - LC_BASE);
    end

    // Pick the source, offset and write-enable for this access.
    always_comb begin
        src    = SRC_NONE;
        offset = '0;
        we     = 1'b0;
        if (rd || wr) begin
            unique case (rg)
                RG_ZPSTK: begin
                    src = ram_src; offset = addr; we = wr;
                end
                RG_LOW: begin
                    src = SRC_MAIN; offset = addr; we = wr;
                end
                RG_IO: ;
                default: begin
                    if (wr) begin
                        if (card_ok && !lc_wr_inh) begin
                            src = ram_src; offset = lc_off; we = 1'b1;
                        end
                    end else if (card_ok && lc_rd_en) begin
                        src = ram_src; offset = lc_off;
                    end else begin
                        src = SRC_ROM; offset = rom_off;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/aux_zp_status.sv
// Builds the data returned to the CPU: the bus value passes through,
// except that a read of STAT_ADDR replaces bit 7 with the flag.
module aux_zp_status #(
    parameter logic [15:0] STAT_ADDR = 16'hC016
) (
    input  logic [15:0] addr,
    input  logic        rd,
    input  logic        wr,
    input  logic        flag,
    input  logic [7:0]  din,
    output logic [7:0]  dout
);
    // Merge the flag into bit 7 on a status read.
    always_comb begin
        if (rd && !wr && addr == STAT_ADDR) dout = {flag, din[6:0]};
        else                                dout = din;
    end
endmodule

// File: rtl/aux_zp_mapper.sv
// Top of the auxiliary memory mapper: switch register, address decoder
// and status merge. Outputs are combinational from inputs and the flag.
module aux_zp_mapper
    import aux_map_pkg::*;
#(
    parameter logic [15:0] ROM_BASE  = 16'h0000,
    parameter bit          HAS_CARD  = 1'b1,
    parameter logic [15:0] SW_ADDR   = 16'hC008,
    parameter logic [15:0] STAT_ADDR = 16'hC016
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] cpu_addr,
    input  logic        cpu_rd,
    input  logic        cpu_wr,
    input  logic [7:0]  cpu_din,
    output logic [7:0]  cpu_dout,
    input  logic        lc_present,
    input  logic        lc_rd_en,
    input  logic        lc_wr_inh,
    input  logic        lc_bank1,
    output logic [1:0]  map_src,
    output logic [15:0] map_offset,
    output logic        map_we
);
    logic alt_zp;
    logic acc;

    // Any strobe counts as an access for the soft switch.
    always_comb acc = cpu_rd || cpu_wr;

    aux_zp_switch #(.SW_ADDR(SW_ADDR)) u_switch (
        .clk(clk), .rst_n(rst_n), .addr(cpu_addr), .acc(acc), .flag(alt_zp)
    );

    aux_zp_decode #(.ROM_BASE(ROM_BASE), .HAS_CARD(HAS_CARD)) u_decode (
        .addr(cpu_addr), .rd(cpu_rd), .wr(cpu_wr), .flag(alt_zp),
        .lc_present(lc_present), .lc_rd_en(lc_rd_en),
        .lc_wr_inh(lc_wr_inh), .lc_bank1(lc_bank1),
        .src(map_src), .offset(map_offset), .we(map_we)
    );

    aux_zp_status #(.STAT_ADDR(STAT_ADDR)) u_status (
        .addr(cpu_addr), .rd(cpu_rd), .wr(cpu_wr), .flag(alt_zp),
        .din(cpu_din), .dout(cpu_dout)
    );
endmodule

// File: rtl/aux_zp_mapper_chk.sv
// Property checker for the auxiliary memory mapper, bound to the top.
module aux_zp_mapper_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cpu_addr,
    input logic        cpu_rd,
    input logic        cpu_wr,
    input logic [7:0]  cpu_din,
    input logic [7:0]  cpu_dout,
    input logic        lc_present,
    input logic        lc_wr_inh,
    input logic [1:0]  map_src,
    input logic [15:0] map_offset,
    input logic        map_we,
    input logic        alt_zp
);
    p_switch_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpu_rd || cpu_wr) && cpu_addr == 16'hC009) |=> alt_zp);

    p_switch_clr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpu_rd || cpu_wr) && cpu_addr == 16'hC008) |=> !alt_zp);

    p_low_main_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpu_rd || cpu_wr) && cpu_addr >= 16'h0200 && cpu_addr < 16'hC000)
        |-> (map_src == 2'd0 && map_offset == cpu_addr));

    p_we_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (map_we && cpu_addr >= 16'hD000) |-> (lc_present && !lc_wr_inh));

    p_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_wr && cpu_addr == 16'hC016)
        |-> (cpu_dout[7] == alt_zp && cpu_dout[6:0] == cpu_din[6:0]));

    p_reset_r9: assert property (@(posedge clk)
        !rst_n |=> !alt_zp);

    p_io_none_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:12] == 4'hC) |-> (map_src == 2'd3 && !map_we));

    p_we_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        map_we |-> cpu_wr);
endmodule

bind aux_zp_mapper aux_zp_mapper_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .cpu_din(cpu_din), .cpu_dout(cpu_dout),
    .lc_present(lc_present), .lc_wr_inh(lc_wr_inh), .map_src(map_src),
    .map_offset(map_offset), .map_we(map_we), .alt_zp(alt_zp)
);

// File: tb/aux_zp_mapper_test.sv
// Self-checking bench: a behavioural reference model predicts every
// output each cycle from the requirements.
module aux_zp_mapper_test;
    localparam logic [15:0] ROMB = 16'h0F00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [7:0]  cpu_din = '0;
    logic [7:0]  cpu_dout;
    logic        lc_present = 1'b0, lc_rd_en = 1'b0, lc_wr_inh = 1'b0, lc_bank1 = 1'b0;
    logic [1:0]  map_src;
    logic [15:0] map_offset;
    logic        map_we;

    int checks = 0;
    int errors = 0;
    int mflag  = 0;

    always #4 clk = ~clk;

    aux_zp_mapper #(.ROM_BASE(ROMB), .HAS_CARD(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_din(cpu_din), .cpu_dout(cpu_dout),
        .lc_present(lc_present), .lc_rd_en(lc_rd_en), .lc_wr_inh(lc_wr_inh),
        .lc_bank1(lc_bank1), .map_src(map_src), .map_offset(map_offset),
        .map_we(map_we)
    );

    // Requirement tag for an access, used in failure lines.
    function automatic string tag_of(input int a, input bit rd, input bit wr);
        if (!rd && !wr)             return "R10";
        if (a < 'h200)              return "R2";
        if (a < 'hC000)             return "R3";
        if (a < 'hD000)             return (rd && !wr && a == 'hC016) ? "R8" : "R10";
        if (wr)                     return "R6";
        if (!(lc_present && lc_rd_en)) return "R7";
        return (a < 'hE000) ? "R4" : "R5";
    endfunction

    task automatic check(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Drive one cycle, compare against the model, then advance the model.
    task automatic cycle(input int a, input bit rd, input bit wr, input int din);
        int es, eo, ew, ed;
        int ram;
        string t;
        cpu_addr = a[15:0]; cpu_rd = rd; cpu_wr = wr; cpu_din = din[7:0];
        #2;
        ram = mflag ? 1 : 0;
        es = 3; eo = 0; ew = 0;
        if (rd || wr) begin
            if (a < 'h200) begin es = ram; eo = a; ew = wr; end
            else if (a < 'hC000) begin es = 0; eo = a; ew = wr; end
            else if (a < 'hD000) begin end
            else if (wr) begin
                if (lc_present && !lc_wr_inh) begin
                    es = ram; ew = 1;
                    eo = (a < 'hE000) ? ((lc_bank1 ? 'hD000 : 'hC000) + (a % 'h1000)) : a;
                end
            end else if (lc_present && lc_rd_en) begin
                es = ram;
                eo = (a < 'hE000) ? ((lc_bank1 ? 'hD000 : 'hC000) + (a % 'h1000)) : a;
            end else begin
                es = 2; eo = (int'(ROMB) + a - 'hD000) % 'h10000;
            end
        end
        ed = din;
        if (rd && !wr && a == 'hC016) ed = (mflag * 128) + (din % 128);
        t = tag_of(a, rd, wr);
        check(t, map_src, es, "source");
        check(t, map_offset, eo, "offset");
        check((wr ? "R11" : t), map_we, ew, "write-enable");
        check((a == 'hC016 ? "R8" : t), cpu_dout, ed, "data-out");
        @(posedge clk);
        if ((rd || wr) && (a == 'hC008 || a == 'hC009)) mflag = a % 2;
        @(negedge clk);
    endtask

    task automatic set_lc(input bit p, input bit r, input bit w, input bit b);
        lc_present = p; lc_rd_en = r; lc_wr_inh = w; lc_bank1 = b;
    endtask

    initial begin : watchdog
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: status after reset shows flag clear
        cycle('hC016, 1, 0, 'hFF);
        // R2 with flag clear, then R1 set by read and check on next cycle
        cycle('h0000, 1, 0, 0);
        cycle('h01FF, 0, 1, 0);
        cycle('hC009, 1, 0, 0);
        cycle('h0080, 1, 0, 0);
        cycle('hC016, 1, 0, 'h00);
        // R3 unaffected by flag; edges of low region
        cycle('h0200, 0, 1, 0);
        cycle('hBFFF, 1, 0, 0);
        // R4/R5 RAM reads, both banks, aux source
        set_lc(1, 1, 0, 0);
        cycle('hD000, 1, 0, 0);
        set_lc(1, 1, 0, 1);
        cycle('hDFFF, 1, 0, 0);
        cycle('hE000, 0, 1, 0);
        cycle('hFFFF, 1, 0, 0);
        // R1 clear by write
        cycle('hC008, 0, 1, 0);
        cycle('hD123, 0, 1, 0);
        // R6 write inhibited / no card
        set_lc(1, 1, 1, 0);
        cycle('hD456, 0, 1, 0);
        set_lc(0, 1, 0, 0);
        cycle('hF000, 0, 1, 0);
        // R7 ROM fallback
        cycle('hD000, 1, 0, 0);
        set_lc(1, 0, 0, 0);
        cycle('hFFFF, 1, 0, 0);
        // R10 idle, I/O page, both strobes
        cycle('h1234, 0, 0, 'h55);
        cycle('hC0FF, 0, 1, 0);
        cycle('h0100, 1, 1, 0);
        // Random pass over all regions and controls
        for (int i = 0; i < 3000; i++) begin
            int a, k;
            k = $urandom % 8;
            case (k)
                0: a = $urandom % 'h200;
                1: a = 'h200 + ($urandom % 'hBE00);
                2: a = 'hC008 + ($urandom % 2);
                3: a = 'hC016;
                4: a = 'hC000 + ($urandom % 'h1000);
                default: a = 'hD000 + ($urandom % 'h3000);
            endcase
            set_lc($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2);
            cycle(a, $urandom % 2, $urandom % 2, $urandom % 256);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule